// File: doc/BRIEF.md
# Five-Channel Countdown Timer Register Block

This block puts five independent countdown channels behind one 32-bit word-addressed register interface. Each channel has a control word, a reload value and a live count. The control word holds a prescaler, a run bit, an interrupt-enable bit and a mode bit that selects between stopping at zero and reloading at zero. The block keeps one shared status word with one expiry flag per channel. Software clears this word by writing ones. The block also exposes a fixed watchdog-control word, and it drives one interrupt line per channel.

Requests arrive on a single-cycle valid/write/address/data port and complete in the cycle they are presented. Read data appears on the next clock edge and holds until the next read. Only word-aligned offsets inside a 4 KiB window decode. Any other offset reads as zero and ignores writes. Channels 0 to 3 occupy the low words in two groups, which sit on either side of the status and watchdog words. Channel 4 sits in a separate group starting at 0x40.

Top module: `tmr5_regfile`

## Requirements
- R1: After reset, every control word reads 0x00000005, every reload and count word reads 0, the status word reads 0, the watchdog word reads 0x00000400, read data is 0 and all interrupt lines are low (lines are held low while reset is asserted).
- R2: Control word layout: bits 7:0 prescale, bit 27 periodic, bit 29 interrupt enable, bit 30 run, bit 25 running indicator (reads 1 exactly when run is 1). All other bits, and bit 25 itself, are discarded on write and read back as 0.
- R3: A control write with bit 26 (count restart) set copies the reload value into the count, and bit 26 is not retained. If bit 26 and bit 30 are both written as 1, the run bit stays 0.
- R4: Writing a reload word sets both the reload value and the live count to the written value.
- R5: While running, the count drops by one once every prescale+1 clocks, starting from the control write that sets run. While stopped, the count holds.
- R6: In one-shot mode (bit 27 = 0), the step that finds the count at 1 or 0 leaves the count at 0, sets the channel's status bit and clears the run and running bits.
- R7: In periodic mode, that same step reloads the count from the reload value, sets the status bit and keeps running, so the flag repeats every reload×(prescale+1) clocks.
- R8: Status bit i belongs to channel i. Writing the status word clears each bit written as 1 and leaves bits written as 0 unchanged. An expiry in the same cycle as a clear of the same bit leaves the bit set.
- R9: Interrupt line i is high exactly while status bit i and channel i's interrupt-enable bit are both 1.
- R10: Writes to count words, to the watchdog word, to unmapped offsets and to non-word-aligned addresses change nothing. Reads from unmapped or unaligned addresses return 0.
- R11: A read request is answered on rsp_rdata after the next clock edge, with the register value from before that edge. rsp_rdata holds its value through idle cycles and writes.
- R12: The word map is: control 0x00/0x04/0x20/0x24/0x40, reload 0x08/0x0C/0x28/0x2C/0x48, count 0x10/0x14/0x30/0x34/0x50 for channels 0 to 4, status 0x18, watchdog 0x1C. Offsets such as 0x44 are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq_o | output | 5 | Per-channel interrupt lines |

## Verification
The bound checker watches several rules on every cycle. A channel's expiry must leave its status bit set on the next cycle. A clear that does not collide with an expiry must drop the bit. A one-shot expiry must stop its channel. The interrupt lines must stay low during reset. Unmapped reads must return zero, the watchdog read must return its fixed word, and read data must hold outside read requests. The directed scenarios cover what needs a known history: the prescaled step rate, the exact clock on which a periodic reload happens, set-beats-clear timed onto an expiry edge, restart-with-run, the field masking of control writes, and the irregular placement of channel 4.

// File: rtl/tmr5_pkg.sv
package tmr5_pkg;
  localparam int NUM_CH = 5;
  localparam int DW     = 32;
  localparam int AW     = 12;
  localparam int WAW    = AW - 2;
  localparam int PSW    = 8;
  localparam int CHW    = $clog2(NUM_CH);

  // control word bit positions (software-visible)
  localparam int EN_B   = 30;
  localparam int IE_B   = 29;
  localparam int PER_B  = 27;
  localparam int CRST_B = 26;
  localparam int ACT_B  = 25;

  localparam logic [DW-1:0] CTL_RST  = 32'h0000_0005;
  localparam logic [DW-1:0] WDOG_RST = 32'h0000_0400;

  typedef enum logic [2:0] {
    K_NONE, K_CTL, K_INIT, K_CNT, K_STAT, K_WDOG
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [CHW-1:0]   ch;
  } reg_sel_t;

  typedef struct packed {
    logic           en;
    logic           ie;
    logic           per;
    logic [PSW-1:0] pre;
  } ctl_t;

  function automatic reg_kind_e kind_of(input int unsigned k);
    case (k)
      0:       return K_CTL;
      1:       return K_INIT;
      default: return K_CNT;
    endcase
  endfunction

  // word index -> register kind and channel
  function automatic reg_sel_t decode_word(input logic [WAW-1:0] w);
    reg_sel_t    s;
    int unsigned wi, off, grp;
    wi     = 32'(w);
    s.kind = K_NONE;
    s.ch   = '0;
    if (wi == 6) begin
      s.kind = K_STAT;
    end else if (wi == 7) begin
      s.kind = K_WDOG;
    end else if (wi < 14) begin
      grp    = (wi >= 8) ? 1 : 0;
      off    = wi - 8 * grp;
      s.kind = kind_of(off / 2);
      s.ch   = CHW'(off % 2 + 2 * grp);
    end else if (wi >= 16 && wi <= 20 && (wi % 2) == 0) begin
      s.kind = kind_of((wi - 16) / 2);
      s.ch   = CHW'(NUM_CH - 1);
    end
    return s;
  endfunction

  // accept a control write: drop reserved bits, restart overrides run
  function automatic ctl_t ctl_take(input logic [DW-1:0] d);
    ctl_t c;
    c.en  = d[EN_B] & ~d[CRST_B];
    c.ie  = d[IE_B];
    c.per = d[PER_B];
    c.pre = d[PSW-1:0];
    return c;
  endfunction

  function automatic logic [DW-1:0] ctl_word(input ctl_t c);
    logic [DW-1:0] w;
    w          = '0;
    w[EN_B]    = c.en;
    w[ACT_B]   = c.en;
    w[IE_B]    = c.ie;
    w[PER_B]   = c.per;
    w[PSW-1:0] = c.pre;
    return w;
  endfunction
endpackage

// File: rtl/tmr5_addr_dec.sv
module tmr5_addr_dec
  import tmr5_pkg::*;
(
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel,
  output logic          hit
);
  reg_sel_t raw;
  logic     aligned;

  assign raw     = decode_word(addr[AW-1:2]);
  assign aligned = (addr[1:0] == 2'b00);
  assign hit     = aligned && (raw.kind != K_NONE);

  always_comb begin
    sel = raw;
    if (!aligned) sel.kind = K_NONE;
  end
endmodule

// File: rtl/tmr5_chan.sv
module tmr5_chan
  import tmr5_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          init_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_rd,
  output logic [DW-1:0] init_rd,
  output logic [DW-1:0] cnt_rd,
  output logic          zero_evt,
  output logic          en_o,
  output logic          per_o,
  output logic          ie_o
);
  ctl_t           ctl_q;
  logic [DW-1:0]  init_q;
  logic [DW-1:0]  cnt_q;
  logic [PSW-1:0] pc_q;
  logic           tick;
  logic           last;
  logic           busy_wr;

  assign busy_wr  = ctl_we || init_we;
  assign tick     = ctl_q.en && (pc_q == ctl_q.pre);
  assign last     = (cnt_q <= DW'(1));
  assign zero_evt = tick && last && !busy_wr;

  assign ctl_rd  = ctl_word(ctl_q);
  assign init_rd = init_q;
  assign cnt_rd  = cnt_q;
  assign en_o    = ctl_q.en;
  assign per_o   = ctl_q.per;
  assign ie_o    = ctl_q.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= ctl_take(CTL_RST);
      init_q <= '0;
      cnt_q  <= '0;
      pc_q   <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_take(wdata);
      pc_q  <= '0;
      if (wdata[CRST_B]) cnt_q <= init_q;
    end else if (init_we) begin
      init_q <= wdata;
      cnt_q  <= wdata;
      pc_q   <= '0;
    end else if (ctl_q.en) begin
      if (tick) begin
        pc_q <= '0;
        if (last) begin
          if (ctl_q.per) begin
            cnt_q <= init_q;
          end else begin
            cnt_q    <= '0;
            ctl_q.en <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr5_stat.sv
module tmr5_stat
  import tmr5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= (stat_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/tmr5_regfile.sv
module tmr5_regfile
  import tmr5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  reg_sel_t          sel;
  logic              hit;
  logic              wr_hit;
  logic              rd_req;
  logic [DW-1:0]     rd_val;
  logic [NUM_CH-1:0] ctl_we, init_we;
  logic [NUM_CH-1:0] zero_evt, en_vec, per_vec, ie_vec;
  logic [NUM_CH-1:0] stat_q, stat_clr;
  logic [DW-1:0]     ctl_rd  [NUM_CH];
  logic [DW-1:0]     init_rd [NUM_CH];
  logic [DW-1:0]     cnt_rd  [NUM_CH];

  tmr5_addr_dec u_dec (
    .addr (req_addr),
    .sel  (sel),
    .hit  (hit)
  );

  assign wr_hit = req_valid && req_write && hit;
  assign rd_req = req_valid && !req_write;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ctl_we[i]  = wr_hit && (sel.kind == K_CTL)  && (sel.ch == CHW'(i));
    assign init_we[i] = wr_hit && (sel.kind == K_INIT) && (sel.ch == CHW'(i));

    tmr5_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we[i]),
      .init_we  (init_we[i]),
      .wdata    (req_wdata),
      .ctl_rd   (ctl_rd[i]),
      .init_rd  (init_rd[i]),
      .cnt_rd   (cnt_rd[i]),
      .zero_evt (zero_evt[i]),
      .en_o     (en_vec[i]),
      .per_o    (per_vec[i]),
      .ie_o     (ie_vec[i])
    );
  end

  assign stat_clr = (wr_hit && sel.kind == K_STAT) ? req_wdata[NUM_CH-1:0] : '0;

  tmr5_stat u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (zero_evt),
    .clr_i  (stat_clr),
    .stat_o (stat_q)
  );

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      K_STAT: rd_val = DW'(stat_q);
      K_WDOG: rd_val = WDOG_RST;
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (sel.ch == CHW'(i)) begin
            if (sel.kind == K_CTL)  rd_val = ctl_rd[i];
            if (sel.kind == K_INIT) rd_val = init_rd[i];
            if (sel.kind == K_CNT)  rd_val = cnt_rd[i];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (rd_req) rsp_rdata <= rd_val;
  end

  assign irq_o = {NUM_CH{rst_n}} & stat_q & ie_vec;
endmodule

// File: rtl/tmr5_regfile_chk.sv
module tmr5_regfile_chk
  import tmr5_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [DW-1:0]     rsp_rdata,
  input logic [NUM_CH-1:0] irq_o,
  input logic              hit,
  input logic [NUM_CH-1:0] zero_evt,
  input logic [NUM_CH-1:0] stat_q,
  input logic [NUM_CH-1:0] stat_clr,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] per_vec
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R8
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt[i] |=> stat_q[i]);
    // R8
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[i] && !zero_evt[i]) |=> !stat_q[i]);
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt[i] && !per_vec[i]) |=> !en_vec[i]);
  end

  // R1
  rst_irq_chk: assert property (@(posedge clk)
    !rst_n |-> (irq_o == '0));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !hit) |=> (rsp_rdata == '0));

  // R10
  wdog_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == AW'(12'h01C)) |=> (rsp_rdata == WDOG_RST));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));
endmodule

bind tmr5_regfile tmr5_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .irq_o     (irq_o),
  .hit       (hit),
  .zero_evt  (zero_evt),
  .stat_q    (stat_q),
  .stat_clr  (stat_clr),
  .en_vec    (en_vec),
  .per_vec   (per_vec)
);

// File: tb/tmr5_regfile_bench.sv
`timescale 1ns/1ps
module tmr5_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [4:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr5_regfile u_tmr5_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  localparam logic [11:0] A_STAT = 12'h018;
  localparam logic [11:0] A_WDOG = 12'h01C;

  function automatic logic [11:0] a_ctl(input int ch);
    if (ch < 2)      return 12'(ch * 4);
    else if (ch < 4) return 12'(32 + (ch - 2) * 4);
    else             return 12'h040;
  endfunction
  function automatic logic [11:0] a_init(input int ch); return a_ctl(ch) + 12'h008; endfunction
  function automatic logic [11:0] a_cnt(input int ch);  return a_ctl(ch) + 12'h010; endfunction

  // expected control readback: run->30 and 25, ie->29, periodic->27, prescale->7:0
  function automatic logic [31:0] ctl_exp(input bit en, input bit ie, input bit per, input logic [7:0] pre);
    return (32'(en) << 30) | (32'(en) << 25) | (32'(ie) << 29) | (32'(per) << 27) | 32'(pre);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata", rsp_rdata, 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    for (int c = 0; c < 5; c++) begin
      rd(a_ctl(c), v);  check("R1 ctl", v, 32'h5);
      rd(a_init(c), v); check("R1 init", v, 32'h0);
      rd(a_cnt(c), v);  check("R1 cnt", v, 32'h0);
    end
    rd(A_STAT, v); check("R1 stat", v, 32'h0);
    rd(A_WDOG, v); check("R1 wdog", v, 32'h400);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(a_init(0), 32'd3);
    rd(a_init(0), v); check("R4 init", v, 32'd3);
    rd(a_cnt(0), v);  check("R4 cnt", v, 32'd3);
    wr(a_ctl(0), ctl_exp(1, 0, 0, 8'd0));
    idle(5);
    rd(a_cnt(0), v); check("R6 cnt at zero", v, 32'd0);
    rd(a_ctl(0), v); check("R6 run cleared", v, 32'h0);
    rd(A_STAT, v);   check("R6 flag", v, 32'h1);
    check("R9 irq masked", 32'(irq_o), 32'h0);
  endtask

  task automatic t_ch4();
    logic [31:0] v;
    wr(12'h048, 32'd1);
    rd(12'h048, v); check("R12 ch4 init", v, 32'd1);
    rd(12'h050, v); check("R12 ch4 cnt", v, 32'd1);
    rd(12'h044, v); check("R12 hole", v, 32'h0);
    wr(12'h040, ctl_exp(1, 0, 0, 8'd0));
    idle(1);
    rd(12'h050, v); check("R6 ch4 cnt", v, 32'd0);
    rd(A_STAT, v);  check("R8 bit4", v, 32'h11);
    rd(12'h040, v); check("R6 ch4 stop", v, 32'h0);
  endtask

  task automatic t_irq_w1c();
    logic [31:0] v;
    wr(a_ctl(0), ctl_exp(0, 1, 0, 8'd0));
    check("R9 irq on", 32'(irq_o), 32'h1);
    wr(A_STAT, 32'h1);
    check("R9 irq off", 32'(irq_o), 32'h0);
    rd(A_STAT, v); check("R8 partial clear", v, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); check("R8 clear", v, 32'h0);
    wr(a_ctl(0), 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(a_init(1), 32'd10);
    wr(a_ctl(1), ctl_exp(1, 0, 0, 8'd1));
    rd(a_ctl(1), v); check("R2 running", v, ctl_exp(1, 0, 0, 8'd1));
    idle(5);
    rd(a_cnt(1), v); check("R5 div2", v, 32'd7);
    wr(a_ctl(1), ctl_exp(0, 0, 0, 8'd1));
    idle(4);
    rd(a_cnt(1), v); check("R5 hold", v, 32'd7);
    wr(a_init(3), 32'd5);
    wr(a_ctl(3), ctl_exp(1, 0, 0, 8'd2));
    idle(9);
    rd(a_cnt(3), v); check("R5 div3", v, 32'd2);
    wr(a_ctl(3), ctl_exp(0, 0, 0, 8'd2));
  endtask

  task automatic t_ctl_fields();
    logic [31:0] v;
    wr(a_ctl(1), 32'h9BFF_FF07);
    rd(a_ctl(1), v); check("R2 masking", v, ctl_exp(0, 0, 1, 8'd7));
    wr(a_ctl(0), 32'h4400_0000);
    rd(a_ctl(0), v); check("R3 run dropped", v, 32'h0);
    rd(a_cnt(0), v); check("R3 restart", v, 32'd3);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(a_init(2), 32'd4);
    wr(a_ctl(2), ctl_exp(1, 1, 1, 8'd0));
    idle(5);
    rd(a_cnt(2), v); check("R7 reload", v, 32'd3);
    rd(a_ctl(2), v); check("R7 keeps running", v, ctl_exp(1, 1, 1, 8'd0));
    rd(A_STAT, v);   check("R7 flag", v, 32'h4);
    check("R9 irq ch2", 32'(irq_o), 32'h4);
    wr(A_STAT, 32'h4);
    rd(A_STAT, v);   check("R8 clear off-edge", v, 32'h0);
    idle(1);
    wr(A_STAT, 32'h4);
    rd(A_STAT, v);   check("R8 set wins", v, 32'h4);
    wr(a_ctl(2), 32'h0);
    wr(A_STAT, 32'h4);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(a_cnt(0), 32'h55);
    rd(a_cnt(0), v); check("R10 cnt ro", v, 32'd3);
    wr(A_WDOG, 32'h0);
    rd(A_WDOG, v);   check("R10 wdog ro", v, 32'h400);
    wr(12'h03C, 32'hFFFF_FFFF);
    rd(12'h03C, v);  check("R10 unmapped", v, 32'h0);
    rd(A_STAT, v);   check("R10 no side effect", v, 32'h0);
    wr(12'h002, ctl_exp(0, 1, 1, 8'd9));
    rd(a_ctl(0), v); check("R10 unaligned wr", v, 32'h0);
    rd(12'h001, v);  check("R10 unaligned rd", v, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    rd(A_WDOG, v);
    idle(3);
    check("R11 idle hold", rsp_rdata, 32'h400);
    wr(a_ctl(0), 32'h0);
    check("R11 write hold", rsp_rdata, 32'h400);
  endtask

  initial begin
    idle(4);
    check("R1 irq in reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_ch4();
    t_irq_w1c();
    t_prescale();
    t_ctl_fields();
    t_periodic();
    t_ignored();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule